// File: doc/BRIEF.md
# SPI Daisy-Chain Host Sequencer

This block is the host end of a serial chain of N identical 16-bit SPI slaves. All slaves share chip select and the serial clock. Host MOSI feeds slave 0, each slave's output feeds the next one, and host MISO comes from slave N-1. Software supplies a table with one command per slave: a write (address plus data byte) or a read (address). The block then runs the whole transaction without further help and returns one result per slave.

Every chip-select frame carries exactly N 16-bit words. Bits travel from slave 0 towards slave N-1, so the word meant for slave N-1 goes out first. Slaves act on what they hold when chip select rises. An operation that contains at least one read runs a second frame of N no-op words. During that frame the slaves push their answers back. Each answer word has an upper byte of marker 111b plus the address, and a lower byte holding the data.

Control is a plain start/busy/done handshake. There is no streaming interface and no back-pressure: the command table is captured on the accepted start, and the result table holds its value until the next accepted start.

Top module: `spi_dc_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, busy is 0, done is 0, and res_valid and res_err are all 0.
- R2: SPI mode 0 is used. SCK is 0 whenever CS is high. Data goes out MSB first, and MOSI never changes on an SCK rising edge. SCK high and low phases each last SCK_HALF clocks. The instruction byte is {op[2:0], addr[4:0]}, with write op 3'b010, read op 3'b001 and no-op 3'b000. The second byte is the write data, and is 0 for reads and no-ops.
- R3: Within a frame, the k-th word sent (k from 0) belongs to slave N-1-k.
- R4: An operation with no reads uses exactly one CS frame of 16*N SCK rising edges.
- R5: An operation with any read uses a second frame of N no-op words, also 16*N rising edges. CS stays high for at least 2*SCK_HALF clocks between the two frames.
- R6: The k-th word received in the second frame belongs to slave N-1-k. For each reading slave, its low byte goes to res_data and res_valid is set. Slaves that wrote never have res_valid set.
- R7: res_err is set for a reading slave whose received upper byte is not {3'b111, addr}. res_valid is still set for that slave.
- R8: start while busy is 1 is ignored. The running operation and its latched commands are not affected, and no further operation follows.
- R9: done is high for exactly one clock, in the first cycle with CS high after the final frame. busy is 0 in that same cycle.
- R10: An accepted start clears res_valid and res_err. Results then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| cmd_rd | input | N | Per-slave read (1) or write (0) |
| cmd_addr | input | 5*N | Per-slave register address, slave i at [5i+:5] |
| cmd_data | input | 8*N | Per-slave write data, slave i at [8i+:8] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 8*N | Per-slave read data |
| res_valid | output | N | Per-slave read result present |
| res_err | output | N | Per-slave marker or address mismatch |
| spi_cs_n | output | 1 | Shared chip select, active low |
| spi_sck | output | 1 | Shared serial clock |
| spi_mosi | output | 1 | Serial data to slave 0 |
| spi_miso | input | 1 | Serial data from slave N-1 |

## Verification
The bench models the chain as connected 16-bit shift registers with per-slave register files, so a design that sends words in chain order lands each write on the mirrored slave. A design that maps returned words forward attaches read data to the wrong slave. A mixed write/read table exposes a sequencer that sets valid for writing slaves or that skips the second frame. A corrupted marker on one slave must flag only that slave. A start pulse injected mid-operation must neither alter the writes nor launch a second operation. A later write-only run must find the earlier read results cleared.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_NOP  = 3'b000;
  localparam logic [OP_W-1:0] OP_RD   = 3'b001;
  localparam logic [OP_W-1:0] OP_WR   = 3'b010;
  localparam logic [OP_W-1:0] OP_MARK = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/spi_dc_tick.sv
module spi_dc_tick #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCK_HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run); // R2
endmodule

// File: rtl/spi_dc_shift.sv
module spi_dc_shift
  import spi_dc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic              last_bit,
  output logic [WORD_W-1:0] rx_word
);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-1:0] tx;
  logic [BW-1:0]     bit_cnt;

  assign mosi     = tx[WORD_W-1];
  assign last_bit = (bit_cnt == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx      <= '0;
      rx_word <= '0;
      bit_cnt <= '0;
    end else begin
      if (rise) rx_word <= {rx_word[WORD_W-2:0], miso};
      if (load) begin
        tx      <= load_word;
        bit_cnt <= '0;
      end else if (fall) begin
        tx      <= {tx[WORD_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R2
  AST_NO_LOAD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && load)); // R2
endmodule

// File: rtl/spi_dc_result.sv
module spi_dc_result
  import spi_dc_pkg::*;
#(
  parameter int N_DEV = 4,
  localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    capture,
  input  logic [IW-1:0]           dev_idx,
  input  logic [WORD_W-1:0]       rx_word,
  input  logic [N_DEV-1:0]        rd_mask,
  input  logic [N_DEV*ADDR_W-1:0] addr_flat,
  output logic [N_DEV*BYTE_W-1:0] res_data,
  output logic [N_DEV-1:0]        res_valid,
  output logic [N_DEV-1:0]        res_err
);
  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic hit;
    logic [BYTE_W-1:0] expect_hdr;
    assign hit        = capture && (dev_idx == IW'(d)) && rd_mask[d];
    assign expect_hdr = {OP_MARK, addr_flat[d*ADDR_W +: ADDR_W]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_data[d*BYTE_W +: BYTE_W] <= '0;
        res_valid[d] <= 1'b0;
        res_err[d]   <= 1'b0;
      end else if (clear) begin
        res_valid[d] <= 1'b0;
        res_err[d]   <= 1'b0;
      end else if (hit) begin
        res_data[d*BYTE_W +: BYTE_W] <= rx_word[BYTE_W-1:0];
        res_valid[d] <= 1'b1;
        res_err[d]   <= (rx_word[WORD_W-1:BYTE_W] != expect_hdr);
      end
    end

    AST_VALID_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[d] |-> rd_mask[d]); // R6
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      res_err[d] |-> res_valid[d]); // R7
  end
endmodule

// File: rtl/spi_dc_seq.sv
module spi_dc_seq
  import spi_dc_pkg::*;
#(
  parameter int N_DEV    = 4,
  parameter int SCK_HALF = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_DEV-1:0]        cmd_rd,
  input  logic [N_DEV*ADDR_W-1:0] cmd_addr,
  input  logic [N_DEV*BYTE_W-1:0] cmd_data,
  output logic                    busy,
  output logic                    done,
  output logic [N_DEV*BYTE_W-1:0] res_data,
  output logic [N_DEV-1:0]        res_valid,
  output logic [N_DEV-1:0]        res_err,
  output logic                    spi_cs_n,
  output logic                    spi_sck,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_DEV - 1);

  seq_state_t state;
  logic [N_DEV-1:0]        rd_q;
  logic [N_DEV*ADDR_W-1:0] addr_q;
  logic [N_DEV*BYTE_W-1:0] data_q;
  logic [IW-1:0]           word_idx;
  logic                    frame2, gap_half, sck_q, cs_n_q, done_q;

  logic tick, rise, fall, load, last_bit, accept;
  logic [IW-1:0]     ld_idx, ld_dev;
  logic [WORD_W-1:0] ld_word, rx_word;

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign accept   = (state == ST_IDLE) && start;

  spi_dc_tick #(.SCK_HALF(SCK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  assign rise = (state == ST_SHIFT) && tick && !sck_q;
  assign fall = (state == ST_SHIFT) && tick &&  sck_q;
  assign load = ((state == ST_LEAD) && tick) ||
                (fall && last_bit && (word_idx != LAST_IDX));

  // word k of a frame targets device N-1-k
  always_comb begin
    ld_idx = (state == ST_LEAD) ? '0 : word_idx + 1'b1;
    ld_dev = LAST_IDX - ld_idx;
    if (frame2)
      ld_word = {OP_NOP, {ADDR_W{1'b0}}, {BYTE_W{1'b0}}};
    else if (rd_q[ld_dev])
      ld_word = {OP_RD, addr_q[ld_dev*ADDR_W +: ADDR_W], {BYTE_W{1'b0}}};
    else
      ld_word = {OP_WR, addr_q[ld_dev*ADDR_W +: ADDR_W],
                 data_q[ld_dev*BYTE_W +: BYTE_W]};
  end

  spi_dc_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(ld_word),
    .rise(rise), .fall(fall), .miso(spi_miso), .mosi(spi_mosi),
    .last_bit(last_bit), .rx_word(rx_word)
  );

  spi_dc_result #(.N_DEV(N_DEV)) u_result (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .capture(fall && last_bit && frame2),
    .dev_idx(LAST_IDX - word_idx), .rx_word(rx_word),
    .rd_mask(rd_q), .addr_flat(addr_q),
    .res_data(res_data), .res_valid(res_valid), .res_err(res_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rd_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      word_idx <= '0;
      frame2   <= 1'b0;
      gap_half <= 1'b0;
      sck_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          rd_q     <= cmd_rd;
          addr_q   <= cmd_addr;
          data_q   <= cmd_data;
          cs_n_q   <= 1'b0;
          frame2   <= 1'b0;
          word_idx <= '0;
          state    <= ST_LEAD;
        end
        ST_LEAD: if (tick) state <= ST_SHIFT;
        ST_SHIFT: begin
          if (rise) sck_q <= 1'b1;
          if (fall) begin
            sck_q <= 1'b0;
            if (last_bit) begin
              if (word_idx == LAST_IDX) state <= ST_TAIL;
              else word_idx <= word_idx + 1'b1;
            end
          end
        end
        ST_TAIL: if (tick) begin
          cs_n_q <= 1'b1;
          if (!frame2 && (|rd_q)) begin
            gap_half <= 1'b0;
            state    <= ST_GAP;
          end else begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_half) begin
            cs_n_q   <= 1'b0;
            frame2   <= 1'b1;
            word_idx <= '0;
            state    <= ST_LEAD;
          end else begin
            gap_half <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SCK_LOW_OFF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R2
  AST_MOSI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && spi_cs_n)); // R9
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(rd_q) && $stable(addr_q) && $stable(data_q))); // R8
  AST_SECOND_FRAME_READ: assert property (@(posedge clk) disable iff (!rst_n)
    frame2 |-> (|rd_q)); // R5
endmodule

// File: tb/spi_dc_seq_test.sv
module spi_dc_seq_test;
  localparam int N    = 4;
  localparam int HALF = 2;
  localparam int AW   = 5;
  localparam int BW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0]    cmd_rd = '0;
  logic [N*AW-1:0] cmd_addr = '0;
  logic [N*BW-1:0] cmd_data = '0;
  logic busy, done, spi_cs_n, spi_sck, spi_mosi, spi_miso;
  logic [N*BW-1:0] res_data;
  logic [N-1:0] res_valid, res_err;

  always #10 clk = ~clk;

  spi_dc_seq #(.N_DEV(N), .SCK_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .done(done),
    .res_data(res_data), .res_valid(res_valid), .res_err(res_err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int total = 0, bad = 0;
  bit finished = 0, armed = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural chain of slaves
  logic [15:0] dsr [N];
  logic [7:0]  dmem [N][32];
  int bad_dev = -1;
  int rises = 0, frames = 0, done_cnt = 0;
  int gap = 0, min_gap = 1000;
  assign spi_miso = dsr[N-1][15];

  initial begin
    for (int i = 0; i < N; i++) begin
      dsr[i] = '0;
      for (int a = 0; a < 32; a++) dmem[i][a] = '0;
    end
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    dsr[0] <= {dsr[0][14:0], spi_mosi};
    for (int i = 1; i < N; i++) dsr[i] <= {dsr[i][14:0], dsr[i-1][15]};
    rises++;
  end

  always @(negedge spi_cs_n) if (armed) frames++;

  always @(posedge spi_cs_n) if (armed) begin
    chk(rises == 16 * N, "R4/R5 rises per frame", rises, 16 * N);
    rises = 0;
    for (int i = 0; i < N; i++) begin
      if (dsr[i][15:13] == 3'b010)
        dmem[i][dsr[i][12:8]] = dsr[i][7:0];
      else if (dsr[i][15:13] == 3'b001)
        dsr[i] <= {(i == bad_dev) ? 3'b101 : 3'b111, dsr[i][12:8], dmem[i][dsr[i][12:8]]};
    end
  end

  // per-clock reference of the handshake and pin idle rules
  logic in_op = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) in_op <= 1'b0;
    else if (done) in_op <= 1'b0;
    else if (!in_op && start) in_op <= 1'b1;
  end

  always @(negedge clk) if (armed) begin
    chk(busy == (in_op && !done), "R8/R9 busy model", busy, in_op && !done);
    chk(!(spi_cs_n && spi_sck), "R2 sck idle low", spi_sck, 0);
    if (done) done_cnt++;
    if (busy && spi_cs_n) gap++;
    else if (!spi_cs_n) begin
      if (gap > 0 && gap < min_gap) min_gap = gap;
      gap = 0;
    end
  end

  logic [N-1:0]    e_rd;
  logic [N*AW-1:0] e_addr;
  logic [N*BW-1:0] e_data;

  task automatic launch(input logic [N-1:0] rd, input logic [N*AW-1:0] a, input logic [N*BW-1:0] d);
    @(negedge clk);
    cmd_rd = rd; cmd_addr = a; cmd_data = d;
    frames = 0; done_cnt = 0; min_gap = 1000; gap = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [N-1:0] rd, input logic [N*AW-1:0] a, input logic [N*BW-1:0] d);
    launch(rd, a, d);
    finish_op();
  endtask

  task automatic check_reads(input logic [N-1:0] rd, input logic [N*AW-1:0] a, input logic [N-1:0] exp_err);
    for (int i = 0; i < N; i++) begin
      if (rd[i]) begin
        chk(res_valid[i] == 1'b1, "R6 valid for reader", res_valid[i], 1);
        chk(res_data[i*BW +: BW] == dmem[i][a[i*AW +: AW]], "R6 read data slot",
            res_data[i*BW +: BW], dmem[i][a[i*AW +: AW]]);
      end else begin
        chk(res_valid[i] == 1'b0, "R6 no valid for writer", res_valid[i], 0);
      end
    end
    chk(res_err == exp_err, "R7 error flags", res_err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1 && spi_sck == 0, "R1 pins at reset", {spi_cs_n, spi_sck}, 2'b10);
    chk(busy == 0 && done == 0, "R1 busy/done at reset", {busy, done}, 0);
    chk(res_valid == 0 && res_err == 0, "R1 results at reset", {res_valid, res_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    armed = 1;

    // R3: distinct write per device, lands on matching slave
    for (int i = 0; i < N; i++) begin
      e_addr[i*AW +: AW] = AW'(3 + 5 * i);
      e_data[i*BW +: BW] = BW'(8'hA1 + 8'h11 * i);
    end
    run_op('0, e_addr, e_data);
    for (int i = 0; i < N; i++)
      chk(dmem[i][3 + 5 * i] == e_data[i*BW +: BW], "R3 write order",
          dmem[i][3 + 5 * i], e_data[i*BW +: BW]);
    chk(frames == 1, "R4 one frame for writes", frames, 1);
    chk(done_cnt == 1, "R9 single done", done_cnt, 1);

    // all read back
    run_op('1, e_addr, '0);
    chk(frames == 2, "R5 two frames for reads", frames, 2);
    chk(min_gap >= 2 * HALF, "R5 gap between frames", min_gap, 2 * HALF);
    check_reads('1, e_addr, '0);

    // mixed table: 0 write, 1 read, 2 read untouched addr, 3 write
    e_rd = 4'b0110;
    e_addr[0 +: AW] = 5'd20; e_data[0 +: BW] = 8'h5C;
    e_addr[2*AW +: AW] = 5'd30;
    e_addr[3*AW +: AW] = 5'd1; e_data[3*BW +: BW] = 8'hE7;
    run_op(e_rd, e_addr, e_data);
    chk(dmem[0][20] == 8'h5C, "R6 mixed write dev0", dmem[0][20], 8'h5C);
    chk(dmem[3][1] == 8'hE7, "R6 mixed write dev3", dmem[3][1], 8'hE7);
    check_reads(e_rd, e_addr, '0);

    // R7: one slave returns a bad marker
    bad_dev = 2;
    run_op('1, e_addr, '0);
    check_reads('1, e_addr, 4'b0100);
    bad_dev = -1;

    // R10: write-only run clears earlier results
    for (int i = 0; i < N; i++) e_data[i*BW +: BW] = BW'(8'h30 + i);
    run_op('0, e_addr, e_data);
    chk(res_valid == 0 && res_err == 0, "R10 results cleared", {res_valid, res_err}, 0);

    // R8: start during busy is ignored
    launch('0, e_addr, e_data);
    repeat (100) @(negedge clk);
    cmd_data = {N*BW{1'b1}}; cmd_rd = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_op();
    for (int i = 0; i < N; i++)
      chk(dmem[i][e_addr[i*AW +: AW]] == e_data[i*BW +: BW], "R8 latched writes kept",
          dmem[i][e_addr[i*AW +: AW]], e_data[i*BW +: BW]);
    repeat (30) @(negedge clk);
    chk(busy == 0 && frames == 1, "R8 no extra operation", {busy, frames[7:0]}, 1);
    chk(done_cnt == 1, "R9 single done after ignored start", done_cnt, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule